// File: doc/BRIEF.md
# Sign-Controlled Packed Correlation Accumulator

This block is an execution unit for correlating a stream of packed 8-bit samples against binary (±1) code sequences. It keeps an array of accumulators arranged as rows of packed 8-bit lanes. Each operation presents one packed operand word and one control word that carries one sign bit per row. Every row then adds the whole operand word into itself, lane by lane, or subtracts it. The sign bit of that row picks which. A single issue therefore stands in for a full grid of small multiplies by ±1 and their additions, and the hardware for it is nothing more than one adder/subtractor per accumulator lane.

Software-side logic issues an operation with `acc_en` and can wipe the whole array with `clr`. It reads results back one row at a time through a combinational select port. Results land in the cycle after issue. Operations may be issued on every cycle with no bubbles.

Top module: `sgn_corr_array`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every accumulator lane reads as zero.
- R2: When `acc_en` is high, `clr` is low and bit i of `ctl_bits` is 0, each lane j of row i (bits [8j+7:8j] of the row) gains lane j of `opnd` (bits [8j+7:8j]).
- R3: When `acc_en` is high, `clr` is low and bit i of `ctl_bits` is 1, lane j of `opnd` is subtracted from each lane j of row i.
- R4: Lane arithmetic is two's complement modulo 256. Each lane wraps on its own, and no carry or borrow crosses into a neighbouring lane.
- R5: When `clr` is high, every lane of every row becomes zero on the next clock edge. This holds even if `acc_en` is high in the same cycle.
- R6: When `clr` and `acc_en` are both low, no accumulator changes, whatever `opnd` and `ctl_bits` carry.
- R7: The effect of an operation shows on `rd_row` in the cycle after its issue. Operations issued on consecutive cycles all take effect, in order.
- R8: `rd_row` combinationally presents row number `rd_sel` of the array, with lane 0 in the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero the whole array |
| acc_en | input | 1 | Issue one add/subtract operation |
| ctl_bits | input | ROWS (8) | Per-row sign: 0 adds, 1 subtracts |
| opnd | input | LANES*LW (64) | Packed operand lanes |
| rd_sel | input | clog2(ROWS) (3) | Row to present on the read port |
| rd_row | output | LANES*LW (64) | Selected accumulator row |

## Verification
The bench builds the unit with its default shape of eight rows of eight 8-bit lanes. This is the full-size grid, so the mixed sign patterns in `ctl_bits` reach every row. The operand values 0x7F, 0x80, 0xFF and 0x01 drive lanes across both the signed and unsigned wrap points, side by side with lanes that must not be disturbed. Runs of operations issued on consecutive cycles, and a clear issued together with an accumulate, are compared against an independent per-lane model on every row.

// File: rtl/sgn_corr_array.sv
module sgn_corr_array #(
  parameter int ROWS  = 8,
  parameter int LANES = 8,
  parameter int LW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         acc_en,
  input  logic [ROWS-1:0]              ctl_bits,
  input  logic [LANES*LW-1:0]          opnd,
  input  logic [$clog2(ROWS)-1:0]      rd_sel,
  output logic [LANES*LW-1:0]          rd_row
);
  localparam int RW = LANES * LW;

  logic [LW-1:0] acc [ROWS][LANES];
  logic [LW-1:0] lane_in [LANES];
  logic [RW-1:0] row_v [ROWS];

  for (genvar j = 0; j < LANES; j++) begin : g_lane_in
    assign lane_in[j] = opnd[j*LW +: LW];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ROWS; i++) begin
      for (int j = 0; j < LANES; j++) begin
        if (!rst_n || clr)
          acc[i][j] <= '0;
        else if (acc_en)
          acc[i][j] <= ctl_bits[i] ? acc[i][j] - lane_in[j] : acc[i][j] + lane_in[j];
      end
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < LANES; j++) begin : g_pack
      assign row_v[i][j*LW +: LW] = acc[i][j];

      p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr && !ctl_bits[i]) |=> acc[i][j] == LW'($past(acc[i][j]) + $past(lane_in[j])));

      p_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr && ctl_bits[i]) |=> acc[i][j] == LW'($past(acc[i][j]) - $past(lane_in[j])));
    end

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> row_v[i] == '0);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !acc_en) |=> $stable(row_v[i]));

    p_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> row_v[i] == '0);
  end

  assign rd_row = row_v[rd_sel];
endmodule

// File: tb/sgn_corr_array_bench.sv
module sgn_corr_array_bench;
  localparam int ROWS = 8, LANES = 8, LW = 8;

  logic clk = 0, rst_n = 0, clr = 0, acc_en = 0;
  logic [ROWS-1:0] ctl_bits = '0;
  logic [63:0] opnd = '0;
  logic [2:0] rd_sel = '0;
  logic [63:0] rd_row;

  always #2ns clk = ~clk;

  sgn_corr_array #(.ROWS(ROWS), .LANES(LANES), .LW(LW)) u_sgn_corr_array (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
    .ctl_bits(ctl_bits), .opnd(opnd), .rd_sel(rd_sel), .rd_row(rd_row));

  typedef struct { logic [2:0] row; logic [63:0] exp; string req; } item_t;
  item_t sb[$];
  logic [7:0] mdl [ROWS][LANES];
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic issue(input bit c, input bit e, input logic [7:0] b, input logic [63:0] op);
    @(negedge clk);
    clr = c; acc_en = e; ctl_bits = b; opnd = op;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < LANES; j++)
        if (c) mdl[i][j] = 8'h00;
        else if (e) mdl[i][j] = b[i] ? mdl[i][j] - op[j*8 +: 8] : mdl[i][j] + op[j*8 +: 8];
  endtask

  task automatic push_all(input string req);
    @(negedge clk);
    clr = 0; acc_en = 0;
    for (int i = 0; i < ROWS; i++) begin
      item_t it;
      it.row = 3'(i);
      for (int j = 0; j < LANES; j++) it.exp[j*8 +: 8] = mdl[i][j];
      it.req = req;
      sb.push_back(it);
    end
    wait (sb.size() == 0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        rd_sel = it.row;
        #1ns;
        nchk++;
        if (rd_row !== it.exp) begin
          nfail++;
          $display("FAIL %s row %0d actual %h expected %h", it.req, it.row, rd_row, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < ROWS; i++) for (int j = 0; j < LANES; j++) mdl[i][j] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    push_all("R1 reset");

    issue(0, 1, 8'h00, 64'h0102_0304_0506_0708);
    push_all("R2 add all rows");

    issue(0, 1, 8'hFF, 64'h0101_0101_0101_0101);
    push_all("R3 subtract all rows");

    issue(0, 1, 8'hA5, 64'h11F0_7F80_FF01_2233);
    issue(0, 1, 8'h3C, 64'h0001_0180_0101_7F00);
    issue(0, 1, 8'h5A, 64'hFFFF_0001_FF00_8080);
    push_all("R7 back-to-back mixed signs");

    issue(1, 0, 8'h00, 64'h0);
    issue(0, 1, 8'h00, 64'h7F00_00FF_0000_7F01);
    issue(0, 1, 8'h00, 64'h0100_0001_0000_0101);
    push_all("R4 lane wrap without carry");

    issue(0, 1, 8'hFF, 64'h0001_0000_0100_0000);
    push_all("R4 lane borrow without spill");

    issue(0, 0, 8'h0F, 64'hDEAD_BEEF_CAFE_F00D);
    issue(0, 0, 8'hF0, 64'h1234_5678_9ABC_DEF0);
    push_all("R6 idle hold");

    issue(1, 1, 8'h00, 64'h0505_0505_0505_0505);
    push_all("R5 clear beats accumulate");

    issue(0, 1, 8'h01, 64'h8877_6655_4433_2211);
    issue(0, 1, 8'h80, 64'h0102_0304_0506_0708);
    push_all("R8 row select and lane order");

    issue(0, 1, 8'h00, 64'h1010_1010_1010_1010);
    issue(1, 0, 8'h00, 64'h0);
    push_all("R5 clear after data");

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule